// File: doc/BRIEF.md
# Skipped-Tick Timer Distributor

This block fans one periodic timer input out to four processors. Each processor has its own down-counter with a sticky wrap flag, which sets how many ticks reach that processor. A rising edge on the timer input counts as one tick. On each tick, every enabled processor's counter steps down by one. Once a counter has wrapped past zero, its flag stays set and every later tick sends a one-cycle set pulse to that processor's timer-interrupt flag. The counter keeps stepping down after the wrap. Software can therefore read back how many ticks went by while the processor was not being interrupted.

Software reaches the four counters through a small register window. A write loads a new count and clears the wrap flag. A read returns the count together with the flag. The timer source and the interrupt flag register that the pulses feed live outside this block.

Top module: `tick_skip_distributor`

## Requirements
- R1: While `rst_n` is low, every counter resets to 0 with its wrap flag clear. `timer_set` is 0 during reset and stays 0 until a tick arrives.
- R2: The counter for processor i lives at byte address 0x380, 0x3C0, 0x700 or 0x740 for i = 0, 1, 2, 3. A read at one of these addresses sets `csr_hit` and returns the count in bits CNT_W-1:0 and the wrap flag in bit CNT_W, with the bits above it read as zero.
- R3: A write to a counter address stores `csr_wdata[CNT_W-1:0]` as the count and clears the wrap flag. The higher data bits have no effect.
- R4: `timer_in` passes through two synchronizing flops. Only a low-to-high transition makes a tick, and that tick updates the counters on the third rising clock edge after the transition is sampled. A high-to-low transition changes neither the counters nor `timer_set`.
- R5: On a tick, an enabled counter treats {flag, count} as a CNT_W+1 bit value. It decrements that value modulo 2^(CNT_W+1) and then ORs the old flag back in. A tick at count 0 therefore sets the flag and leaves the count all ones, and the flag stays set on all later ticks.
- R6: If the flag of an enabled processor is set after a tick's update, `timer_set[i]` is high for exactly the one cycle after that update edge.
- R7: A processor with `cpu_present[i]` low keeps its counter value across ticks and never raises `timer_set[i]`.
- R8: If a software write to processor i's counter happens in the same cycle as a tick, the written value is stored, no decrement is applied, and `timer_set[i]` stays low for that tick. Other processors are updated normally.
- R9: A read at any other address returns 0 with `csr_hit` low. A write at any other address changes no counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| timer_in | input | 1 | Asynchronous periodic timer level |
| cpu_present | input | 4 | Per-processor enable |
| csr_wr | input | 1 | Register write strobe |
| csr_addr | input | ADDR_W | Register byte address |
| csr_wdata | input | DATA_W | Write data |
| csr_rdata | output | DATA_W | Read data for `csr_addr` (combinational) |
| csr_hit | output | 1 | `csr_addr` selects a counter |
| timer_set | output | 4 | Per-processor timer-interrupt set pulse |

## Verification
The assertions take for granted that `cpu_present` and the register inputs are clean synchronous signals. Only `timer_in` may change at any time. They also assume that ticks come from isolated timer edges, so no counter sees two updates on back-to-back edges. The bench drives every synchronous input at the falling clock edge. It holds `timer_in` high and then low for several cycles around each tick, so each edge is seen exactly once. The bench uses a 4-bit count, so the counters wrap many times. It checks every counter and pulse against an arithmetic model after each tick, under different enable masks and after a write that lands in the same cycle as a tick.

// File: rtl/tick_skip_distributor.sv
module tick_skip_distributor #(
  parameter int CNT_W  = 24,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              timer_in,
  input  logic [3:0]        cpu_present,
  input  logic              csr_wr,
  input  logic [ADDR_W-1:0] csr_addr,
  input  logic [DATA_W-1:0] csr_wdata,
  output logic [DATA_W-1:0] csr_rdata,
  output logic              csr_hit,
  output logic [3:0]        timer_set
);
  localparam int NCPU  = 4;
  localparam int REG_W = CNT_W + 1;

  function automatic logic [ADDR_W-1:0] slot_addr(input int i);
    case (i)
      0:       return ADDR_W'(12'h380);
      1:       return ADDR_W'(12'h3C0);
      2:       return ADDR_W'(12'h700);
      default: return ADDR_W'(12'h740);
    endcase
  endfunction

  logic [1:0]                  sync_q;
  logic                        seen_q;
  logic                        tick;
  logic [NCPU-1:0]             wr_sel;
  logic [NCPU-1:0][REG_W-1:0]  cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      seen_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], timer_in};
      seen_q <= sync_q[1];
    end
  end

  assign tick = sync_q[1] & ~seen_q;

  for (genvar i = 0; i < NCPU; i++) begin : g_cpu
    logic [REG_W-1:0] dec;
    assign wr_sel[i] = csr_wr && (csr_addr == slot_addr(i));
    assign dec = (cnt[i] - REG_W'(1)) | {cnt[i][CNT_W], {CNT_W{1'b0}}};

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt[i]       <= '0;
        timer_set[i] <= 1'b0;
      end else if (wr_sel[i]) begin
        cnt[i]       <= {1'b0, csr_wdata[CNT_W-1:0]};
        timer_set[i] <= 1'b0;
      end else if (tick && cpu_present[i]) begin
        cnt[i]       <= dec;
        timer_set[i] <= dec[CNT_W];
      end else begin
        timer_set[i] <= 1'b0;
      end
    end
  end

  always_comb begin
    csr_rdata = '0;
    csr_hit   = 1'b0;
    for (int i = 0; i < NCPU; i++) begin
      if (csr_addr == slot_addr(i)) begin
        csr_rdata[REG_W-1:0] = cnt[i];
        csr_hit              = 1'b1;
      end
    end
  end
endmodule

module tick_skip_distributor_chk #(
  parameter int CNT_W = 24
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [3:0]             cpu_present,
  input logic [CNT_W-1:0]       wdata,
  input logic                   tick,
  input logic [3:0]             wr_sel,
  input logic [3:0][CNT_W:0]    cnt,
  input logic [3:0]             timer_set
);
  for (genvar i = 0; i < 4; i++) begin : g_chk
    // R1
    reset_clear_chk: assert property (@(posedge clk)
      !rst_n |=> cnt[i] == '0 && !timer_set[i]);
    // R3
    write_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_sel[i] |=> cnt[i] == {1'b0, $past(wdata)} && !timer_set[i]);
    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tick && !wr_sel[i] |=> $stable(cnt[i]) && !timer_set[i]);
    // R5
    sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt[i][CNT_W] && !wr_sel[i] |=> cnt[i][CNT_W]);
    // R6
    set_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      timer_set[i] |-> cnt[i][CNT_W]);
    // R6
    set_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      timer_set[i] |=> !timer_set[i]);
    // R7
    absent_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_present[i] && !wr_sel[i] |=> $stable(cnt[i]) && !timer_set[i]);
  end
endmodule

bind tick_skip_distributor tick_skip_distributor_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .cpu_present(cpu_present),
  .wdata(csr_wdata[CNT_W-1:0]),
  .tick(tick),
  .wr_sel(wr_sel),
  .cnt(cnt),
  .timer_set(timer_set)
);

// File: tb/tick_skip_distributor_tb.sv
`timescale 1ns/1ps
module tick_skip_distributor_tb;
  localparam int CNT_W = 4;
  localparam int REG_W = CNT_W + 1;
  localparam logic [31:0] MASK = (32'd1 << REG_W) - 1;
  localparam logic [31:0] FLAG = 32'd1 << CNT_W;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        timer_in = 0;
  logic [3:0]  cpu_present = 4'hF;
  logic        csr_wr = 0;
  logic [11:0] csr_addr = '0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic        csr_hit;
  logic [3:0]  timer_set;

  int checks = 0;
  int errors = 0;
  logic [31:0] model [4];
  logic [3:0]  exp_set;

  tick_skip_distributor #(.CNT_W(CNT_W), .ADDR_W(12), .DATA_W(32)) u_dut (
    .clk(clk), .rst_n(rst_n), .timer_in(timer_in), .cpu_present(cpu_present),
    .csr_wr(csr_wr), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
    .csr_rdata(csr_rdata), .csr_hit(csr_hit), .timer_set(timer_set));

  always #4 clk = ~clk;

  function automatic logic [11:0] addr_of(input int i);
    case (i)
      0: return 12'h380;
      1: return 12'h3C0;
      2: return 12'h700;
      default: return 12'h740;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_reads(input string req);
    for (int i = 0; i < 4; i++) begin
      csr_addr = addr_of(i);
      #1;
      check(req, csr_rdata, model[i]);
      check("R2", {31'd0, csr_hit}, 32'd1);
    end
  endtask

  task automatic sw_write(input int i, input logic [31:0] d);
    @(negedge clk);
    csr_wr = 1; csr_addr = addr_of(i); csr_wdata = d;
    @(negedge clk);
    csr_wr = 0;
    model[i] = d & (FLAG - 1);
  endtask

  task automatic model_tick(input logic [3:0] skip);
    exp_set = '0;
    for (int i = 0; i < 4; i++) begin
      if (cpu_present[i] && !skip[i]) begin
        model[i] = ((model[i] - 1) & MASK) | (model[i] & FLAG);
        exp_set[i] = model[i][CNT_W];
      end
    end
  endtask

  task automatic do_tick(input string req);
    @(negedge clk);
    timer_in = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    model_tick(4'b0);
    check(req, {28'd0, timer_set}, {28'd0, exp_set});
    check_reads(req);
    @(negedge clk);
    check("R6", {28'd0, timer_set}, 32'd0);
    timer_in = 0;
    repeat (5) @(negedge clk);
    // R4 falling edge has no effect
    check("R4", {28'd0, timer_set}, 32'd0);
    check_reads("R4");
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", {28'd0, timer_set}, 32'd0);
    check_reads("R1");
    rst_n = 1;
    @(negedge clk);
    check("R1", {28'd0, timer_set}, 32'd0);

    // R3 upper data bits ignored, flag cleared
    sw_write(0, 32'hABCDEF03);
    sw_write(1, 32'hFFFFFF00);
    sw_write(2, 32'h1234567F);
    sw_write(3, 32'h00000017);
    check_reads("R3");

    // R5 R6 R7 sweep with cpu 2 absent
    cpu_present = 4'b1011;
    for (int t = 0; t < 20; t++) do_tick("R7");

    // R5 R6 full sweep after reload
    cpu_present = 4'b1111;
    sw_write(2, 32'd2);
    sw_write(1, 32'd5);
    for (int t = 0; t < 20; t++) do_tick("R5");

    // R8 write coinciding with a tick
    @(negedge clk);
    timer_in = 1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    csr_wr = 1; csr_addr = addr_of(0); csr_wdata = 32'h0000_0009;
    @(negedge clk);
    csr_wr = 0;
    model[0] = 32'd9;
    model_tick(4'b0001);
    check("R8", {28'd0, timer_set}, {28'd0, exp_set});
    check_reads("R8");
    @(negedge clk);
    timer_in = 0;
    repeat (5) @(negedge clk);

    // R9 unmapped address
    csr_addr = 12'h384;
    #1;
    check("R9", csr_rdata, 32'd0);
    check("R9", {31'd0, csr_hit}, 32'd0);
    @(negedge clk);
    csr_wr = 1; csr_addr = 12'h384; csr_wdata = 32'h5;
    @(negedge clk);
    csr_wr = 0;
    check_reads("R9");
    do_tick("R6");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule